// File: doc/BRIEF.md
# Processor PLL Mode and Autoidle Controller

This block is the control side of one processor clock PLL. Software writes four small registers over a simple write-only bus. They set a bypass-clock divider select, the multiplier and pre-divider, the output divider, a lock-wait length, a 3-bit enable code and a 3-bit autoidle code. From these fields a state machine moves the PLL between four states:

- a gated stop state;
- a low-power bypass state, in which the high-speed bypass clock runs;
- a relocking state, in which the bypass clock is still selected while a lock timer runs;
- a locked state, in which the multiplied clock runs.

The analog loop is not modelled. The lock timer stands in for lock detection. The block drives a lock-request strobe, a bypass select, a clock-gate enable and a state code. It also passes the configuration fields to the PLL.

When autoidle is armed and the idle-conditions input is high, the controller drops to the gated stop state on its own. When the input falls, it returns to the mode that the enable code asks for.

Top module: `pll_mode_ctrl`

## Requirements
- R1: After reset, every field is zero, `state_o` is 0 (stop), and `clk_en_o`, `bypass_sel_o`, `locked_o` and `lock_req_o` are all low.
- R2: Writes select a register by `wr_addr_i`:
  - 0 selects the enable code, in bits 2:0.
  - 1 selects the autoidle code, in bits 2:0.
  - 2 selects config 1: bits 20:19 bypass divider select, bits 18:8 multiplier, bits 6:0 pre-divider.
  - 3 selects config 2: bits 4:0 output divider, bits 15:8 lock-wait count.
  
  Each field appears on its output the cycle after the write edge.
- R3: Enable code 5 gives the bypass state: `state_o`=1, `clk_en_o`=1, `bypass_sel_o`=1, `locked_o`=0. The state changes on the edge after the one that stored the code.
- R4: Enable code 7 enters locked operation through the relocking state (`state_o`=2, `clk_en_o`=1, `bypass_sel_o`=1, `locked_o`=0). Relocking lasts lock-wait + 1 cycles. After it, `state_o`=3, `locked_o`=1 and `bypass_sel_o`=0.
- R5: `lock_req_o` is high for exactly the first cycle of each relock sequence, and only while `state_o`=2.
- R6: Any enable code other than 5 or 7 leads to the stop state with the clock gated.
- R7: A write that changes the multiplier, pre-divider or output divider starts a fresh relock sequence from that same write edge. This applies in the locked state and in the relocking state; in the relocking state the timer restarts.
- R8: A write that leaves the multiplier, pre-divider and output divider unchanged does not disturb the locked state. This holds even if the write changes the bypass divider select or the lock-wait count.
- R9: With autoidle code 1 and `idle_i` high, the controller enters stop on the next edge. With any other autoidle code, `idle_i` has no effect.
- R10: When `idle_i` falls during an autoidle stop, the controller returns to the mode set by the enable code. A return to locked operation passes through relocking.
- R11: `state_o` encodes 0 stop, 1 bypass, 2 relocking, 3 locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 32 | Write data |
| idle_i | input | 1 | Idle conditions met |
| lock_req_o | output | 1 | One-cycle request to start PLL lock |
| bypass_sel_o | output | 1 | Select the high-speed bypass clock |
| clk_en_o | output | 1 | Output clock gate enable |
| locked_o | output | 1 | Lock completed |
| state_o | output | 2 | Current state code |
| byp_div_o | output | 2 | Bypass divider select |
| mult_o | output | 11 | Multiplier |
| prediv_o | output | 7 | Pre-divider |
| postdiv_o | output | 5 | Output divider |

## Verification
The bench targets the boundary between relock and lock. It counts relock cycles for a wait of 2 and a wait of 0. A timer that is off by one would declare lock a cycle early or a cycle late.

It rewrites configuration while the block is locked and while it is relocking. A design that ignores the restart would lock on the old schedule. A design that compares the whole register would relock on a write that only changes the bypass divider.

It raises `idle_i` under autoidle codes 0, 3 and 1. A loose decode of the code would stop the clock when it should not. It then drops `idle_i` to check that the return to locked operation passes through relocking with a fresh lock-request pulse, rather than jumping straight to locked.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  localparam int DATA_W   = 32;
  localparam int BYPDIV_W = 2;
  localparam int MULT_W   = 11;
  localparam int PREDIV_W = 7;
  localparam int POSTDV_W = 5;
  localparam int LWAIT_W  = 8;
  localparam int CODE_W   = 3;

  localparam int BYPDIV_LSB = 19;
  localparam int MULT_LSB   = 8;
  localparam int PREDIV_LSB = 0;
  localparam int POSTDV_LSB = 0;
  localparam int LWAIT_LSB  = 8;

  localparam logic [1:0] A_ENABLE = 2'd0;
  localparam logic [1:0] A_AUTOID = 2'd1;
  localparam logic [1:0] A_CFG1   = 2'd2;
  localparam logic [1:0] A_CFG2   = 2'd3;

  localparam logic [CODE_W-1:0] EN_LOCK   = 3'h7;
  localparam logic [CODE_W-1:0] EN_BYPASS = 3'h5;
  localparam logic [CODE_W-1:0] AI_ON     = 3'h1;

  typedef enum logic [1:0] {
    ST_STOP   = 2'd0,
    ST_BYPASS = 2'd1,
    ST_RELOCK = 2'd2,
    ST_LOCKED = 2'd3
  } pll_state_e;

  typedef struct packed {
    logic [BYPDIV_W-1:0] byp_div;
    logic [MULT_W-1:0]   mult;
    logic [PREDIV_W-1:0] prediv;
    logic [POSTDV_W-1:0] postdiv;
    logic [LWAIT_W-1:0]  lock_wait;
    logic [CODE_W-1:0]   en_code;
    logic [CODE_W-1:0]   ai_code;
  } pll_cfg_t;
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output pll_cfg_t          cfg_o,
  output logic              retune_o
);
  pll_cfg_t cfg_q;

  logic [BYPDIV_W-1:0] new_byp;
  logic [MULT_W-1:0]   new_mult;
  logic [PREDIV_W-1:0] new_prediv;
  logic [POSTDV_W-1:0] new_postdiv;
  logic [LWAIT_W-1:0]  new_lwait;
  logic [CODE_W-1:0]   new_code;

  assign new_byp     = wr_data_i[BYPDIV_LSB +: BYPDIV_W];
  assign new_mult    = wr_data_i[MULT_LSB +: MULT_W];
  assign new_prediv  = wr_data_i[PREDIV_LSB +: PREDIV_W];
  assign new_postdiv = wr_data_i[POSTDV_LSB +: POSTDV_W];
  assign new_lwait   = wr_data_i[LWAIT_LSB +: LWAIT_W];
  assign new_code    = wr_data_i[CODE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_ENABLE: cfg_q.en_code <= new_code;
        A_AUTOID: cfg_q.ai_code <= new_code;
        A_CFG1: begin
          cfg_q.byp_div <= new_byp;
          cfg_q.mult    <= new_mult;
          cfg_q.prediv  <= new_prediv;
        end
        A_CFG2: begin
          cfg_q.postdiv   <= new_postdiv;
          cfg_q.lock_wait <= new_lwait;
        end
        default: ;
      endcase
    end
  end

  // only frequency-setting fields force a relock
  always_comb begin
    retune_o = 1'b0;
    if (wr_en_i) begin
      if (wr_addr_i == A_CFG1)
        retune_o = (new_mult != cfg_q.mult) || (new_prediv != cfg_q.prediv);
      else if (wr_addr_i == A_CFG2)
        retune_o = (new_postdiv != cfg_q.postdiv);
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == limit_i);
endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] en_code_i,
  input  logic [CODE_W-1:0] ai_code_i,
  input  logic              idle_i,
  input  logic              retune_i,
  input  logic              lock_done_i,
  output pll_state_e        state_o,
  output logic              timer_clr_o,
  output logic              lock_req_o
);
  pll_state_e state_q, state_d;
  logic       lock_req_q;
  logic       idle_stop, want_lock, want_byp, start_relock;

  assign idle_stop = (ai_code_i == AI_ON) && idle_i;
  assign want_lock = (en_code_i == EN_LOCK);
  assign want_byp  = (en_code_i == EN_BYPASS);

  always_comb begin
    state_d = state_q;
    if (idle_stop || !(want_lock || want_byp)) begin
      state_d = ST_STOP;
    end else if (want_byp) begin
      state_d = ST_BYPASS;
    end else begin
      unique case (state_q)
        ST_STOP, ST_BYPASS: state_d = ST_RELOCK;
        ST_RELOCK:          state_d = (!retune_i && lock_done_i) ? ST_LOCKED : ST_RELOCK;
        ST_LOCKED:          state_d = retune_i ? ST_RELOCK : ST_LOCKED;
        default:            state_d = ST_STOP;
      endcase
    end
  end

  assign start_relock = (state_d == ST_RELOCK) && ((state_q != ST_RELOCK) || retune_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_STOP;
      lock_req_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      lock_req_q <= start_relock;
    end
  end

  // timer counts from zero in the first relock cycle
  assign timer_clr_o = (state_q != ST_RELOCK) || retune_i;
  assign state_o     = state_q;
  assign lock_req_o  = lock_req_q;
endmodule

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl
  import pll_mode_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                idle_i,
  output logic                lock_req_o,
  output logic                bypass_sel_o,
  output logic                clk_en_o,
  output logic                locked_o,
  output logic [1:0]          state_o,
  output logic [BYPDIV_W-1:0] byp_div_o,
  output logic [MULT_W-1:0]   mult_o,
  output logic [PREDIV_W-1:0] prediv_o,
  output logic [POSTDV_W-1:0] postdiv_o
);
  pll_cfg_t          cfg;
  logic              retune, lock_done, timer_clr;
  pll_state_e        state;
  logic [CODE_W-1:0] en_code, ai_code;

  pll_cfg_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .retune_o  (retune)
  );

  assign en_code = cfg.en_code;
  assign ai_code = cfg.ai_code;

  pll_mode_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_code_i   (en_code),
    .ai_code_i   (ai_code),
    .idle_i      (idle_i),
    .retune_i    (retune),
    .lock_done_i (lock_done),
    .state_o     (state),
    .timer_clr_o (timer_clr),
    .lock_req_o  (lock_req_o)
  );

  pll_lock_timer #(.CNT_W(LWAIT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (timer_clr),
    .limit_i (cfg.lock_wait),
    .done_o  (lock_done)
  );

  assign state_o      = state;
  assign clk_en_o     = (state != ST_STOP);
  assign bypass_sel_o = (state == ST_BYPASS) || (state == ST_RELOCK);
  assign locked_o     = (state == ST_LOCKED);
  assign byp_div_o    = cfg.byp_div;
  assign mult_o       = cfg.mult;
  assign prediv_o     = cfg.prediv;
  assign postdiv_o    = cfg.postdiv;
endmodule

// File: rtl/pll_mode_ctrl_chk.sv
module pll_mode_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       idle_i,
  input logic [2:0] en_code,
  input logic [2:0] ai_code,
  input logic [1:0] state_o,
  input logic       clk_en_o,
  input logic       bypass_sel_o,
  input logic       locked_o,
  input logic       lock_req_o
);
  a_r1_stop_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 |-> !clk_en_o && !bypass_sel_o && !locked_o);

  a_r4_relock_on_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd2 |-> clk_en_o && bypass_sel_o && !locked_o);

  a_r4_lock_via_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(state_o) == 2'd2);

  a_r5_req_in_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_req_o |-> state_o == 2'd2);

  a_r9_autoidle_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ai_code == 3'h1) && idle_i |=> state_o == 2'd0);

  a_r9_idle_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ai_code != 3'h1) && !wr_en_i && (en_code == 3'h7) && (state_o == 2'd3) |=> state_o == 2'd3);
endmodule

bind pll_mode_ctrl pll_mode_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .idle_i       (idle_i),
  .en_code      (en_code),
  .ai_code      (ai_code),
  .state_o      (state_o),
  .clk_en_o     (clk_en_o),
  .bypass_sel_o (bypass_sel_o),
  .locked_o     (locked_o),
  .lock_req_o   (lock_req_o)
);

// File: tb/test_pll_mode_ctrl.sv
`timescale 1ns/1ps
module test_pll_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        idle = 1'b0;
  logic        lock_req, byp_sel, clk_en, locked;
  logic [1:0]  state;
  logic [1:0]  byp_div;
  logic [10:0] mult;
  logic [6:0]  prediv;
  logic [4:0]  postdiv;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [1:0]  st;
    logic        lreq;
    bit          chk_cfg;
    logic [24:0] cfg;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  pll_mode_ctrl i_pll_mode_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .idle_i       (idle),
    .lock_req_o   (lock_req),
    .bypass_sel_o (byp_sel),
    .clk_en_o     (clk_en),
    .locked_o     (locked),
    .state_o      (state),
    .byp_div_o    (byp_div),
    .mult_o       (mult),
    .prediv_o     (prediv),
    .postdiv_o    (postdiv)
  );

  function automatic logic [31:0] cfg1(int bd, int m, int n);
    return (32'(bd) << 19) | (32'(m) << 8) | 32'(n);
  endfunction

  function automatic logic [24:0] pk(int bd, int m, int n, int pd);
    return {2'(bd), 11'(m), 7'(n), 5'(pd)};
  endfunction

  // monitor: compare after each rising edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [5:0] act, exp;
        it = q.pop_front();
        act = {state, clk_en, byp_sel, locked, lock_req};
        exp = {it.st, it.st != 2'd0, (it.st == 2'd1) || (it.st == 2'd2), it.st == 2'd3, it.lreq};
        checks++;
        if (act !== exp) begin
          fails++;
          $display("FAIL %s: {state,clk_en,byp,locked,lreq} actual=%b expected=%b", it.tag, act, exp);
        end
        if (it.chk_cfg) begin
          checks++;
          if ({byp_div, mult, prediv, postdiv} !== it.cfg) begin
            fails++;
            $display("FAIL %s: cfg actual=%h expected=%h", it.tag, {byp_div, mult, prediv, postdiv}, it.cfg);
          end
        end
      end
    end
  end

  task automatic put(logic [1:0] st, logic lreq, string tag);
    item_t it;
    it.st = st; it.lreq = lreq; it.chk_cfg = 0; it.cfg = '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic put_cfg(logic [1:0] st, logic lreq, logic [24:0] c, string tag);
    item_t it;
    it.st = st; it.lreq = lreq; it.chk_cfg = 1; it.cfg = c; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t(logic [1:0] st, logic lreq, string tag);
    put(st, lreq, tag);
    tick();
  endtask

  task automatic w(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    put_cfg(0, 0, pk(0, 0, 0, 0), "R1"); tick();
    // R2 field layout
    w(3, (32'd2 << 8) | 32'd3);
    put_cfg(0, 0, pk(0, 0, 0, 3), "R2"); tick();
    w(2, cfg1(2, 'h123, 5));
    put_cfg(0, 0, pk(2, 'h123, 5, 3), "R2"); tick();
    // R3 bypass
    w(0, 5); t(0, 0, "R3"); t(1, 0, "R3"); t(1, 0, "R3");
    // R4/R5/R11 relock then lock, wait=2
    w(0, 7); t(1, 0, "R4"); t(2, 1, "R5"); t(2, 0, "R4"); t(2, 0, "R4");
    t(3, 0, "R11"); t(3, 0, "R4");
    // R8 unchanged write, bypass-divider-only change
    w(2, cfg1(2, 'h123, 5)); t(3, 0, "R8"); t(3, 0, "R8");
    w(2, cfg1(1, 'h123, 5));
    put_cfg(3, 0, pk(1, 'h123, 5, 3), "R8"); tick();
    t(3, 0, "R8");
    // R7 multiplier change while locked
    w(2, cfg1(1, 'h40, 5));
    put_cfg(2, 1, pk(1, 'h40, 5, 3), "R7"); tick();
    t(2, 0, "R7"); t(2, 0, "R7"); t(3, 0, "R7");
    // R7 output divider change while locked
    w(3, (32'd2 << 8) | 32'd9); t(2, 1, "R7"); t(2, 0, "R7"); t(2, 0, "R7"); t(3, 0, "R7");
    // R9 idle ignored without autoidle code 1
    idle = 1'b1; t(3, 0, "R9"); t(3, 0, "R9"); t(3, 0, "R9");
    w(1, 3); t(3, 0, "R9"); t(3, 0, "R9"); t(3, 0, "R9");
    // R9 autoidle armed
    w(1, 1); t(3, 0, "R9"); t(0, 0, "R9"); t(0, 0, "R9");
    // R10 return to lock via relock
    idle = 1'b0; t(2, 1, "R10"); t(2, 0, "R10"); t(2, 0, "R10"); t(3, 0, "R10");
    // R6 other enable codes
    w(0, 6); t(3, 0, "R6"); t(0, 0, "R6");
    w(0, 0); t(0, 0, "R6"); t(0, 0, "R6");
    // R3 bypass again, R9/R10 autoidle from bypass
    w(0, 5); t(0, 0, "R3"); t(1, 0, "R3");
    idle = 1'b1; t(0, 0, "R9");
    idle = 1'b0; t(1, 0, "R10");
    // R7 restart during relock
    w(0, 7); t(1, 0, "R4"); t(2, 1, "R5");
    w(2, cfg1(1, 'h40, 6)); t(2, 1, "R7"); t(2, 0, "R7"); t(2, 0, "R7"); t(3, 0, "R7");
    // R4 lock wait zero: lock-wait only write is R8
    w(3, 32'd9); t(3, 0, "R8");
    w(0, 5); t(3, 0, "R4"); t(1, 0, "R4");
    w(0, 7); t(1, 0, "R4"); t(2, 1, "R4"); t(3, 0, "R4"); t(3, 0, "R4");
    @(posedge clk); #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule